// File: doc/BRIEF.md
# Pixel Time-to-Digital Counter

This block is the timing logic that sits in every pixel of a photon-counting imager. A start pulse arms the pixel. The next stop pulse, which is a photon detection, freezes a 13-bit arrival time. The code has three parts. The low part is the shared delay-chain phase, which arrives as an 8-bit thermometer word. The middle part is a divide-by-4 counter running on the reference clock. The high part is an 8-bit maximal-length LFSR that steps once per divided-clock period, which keeps the per-pixel area small while covering a long range.

The coarse value is latched one reference cycle after the middle counter freezes. When the frozen middle value is 3, the coarse register may have just stepped. In that case one coarse step is taken back, so the fields always agree. The LFSR state is turned back into binary through a computed lookup. The result is loaded into a register chain and shifted out MSB first under a shift enable. If no photon arrives before the coarse range is used up, the pixel reports an all-ones code and raises an overflow flag.

Top module: `tdc_pixel`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy_o`, `ready_o`, `ovf_o` and `ser_o` are all 0.
- R2: A start pulse sampled while the pixel is idle arms it, and `busy_o` is 1 from the next cycle on. A start pulse at any other time is ignored.
- R3: Let the stop be sampled at the n-th rising edge after the edge that accepted start. Then code bits [12:3] equal n-1 in binary: bits [12:5] are the coarse count and bits [4:3] are the middle count.
- R4: R3 also holds when (n-1) mod 4 equals 3, which is a stop on a coarse step boundary. There is no error of one coarse step.
- R5: Code bits [2:0] equal the number of ones in `fine_therm_i` sampled at the stop edge, clamped to 7. A bubbled (non-monotonic) word is counted the same way.
- R6: `ready_o` rises, and `busy_o` falls, on the second rising edge after the stop edge.
- R7: If n-1 reaches 1019 without an earlier stop, the code is 13'h1FFF and `ovf_o` is 1. This includes a stop at that same edge.
- R8: While `ready_o` is 1, `ser_o` shows code bit 12. Each edge with `shift_en_i` high moves the next lower bit to `ser_o`. After 13 shifts, `ready_o` and `ovf_o` return to 0.
- R9: A start pulse while `ready_o` is 1 has no effect: the held code and `ready_o` are unchanged.
- R10: A stop pulse while the pixel is neither busy nor ready has no effect.
- R11: While `ready_o` is 1 and `shift_en_i` is low, `ser_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm pulse, one cycle |
| stop_i | input | 1 | Photon detection pulse, synchronous to clk |
| fine_therm_i | input | 8 | Shared delay-chain phase, thermometer coded |
| shift_en_i | input | 1 | Advance the readout chain by one bit |
| busy_o | output | 1 | Conversion in progress |
| ready_o | output | 1 | Result held in the readout chain |
| ovf_o | output | 1 | Held result is an overflow |
| ser_o | output | 1 | Serial result, MSB first |

## Verification
The assertions take for granted that `start_i` and `stop_i` are single-cycle pulses already synchronous to `clk`. They also assume that `fine_therm_i` is steady at the edge where the stop is sampled. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It presents the thermometer word in the same cycle as the stop. Its conversion delays stay within the 0 to 1018 range, except where it probes overflow on purpose, both with and without a coincident stop.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int THERM_W   = 8;
    localparam int FINE_W    = 3;
    localparam int MID_W     = 2;
    localparam int CRS_W     = 8;
    localparam int CODE_W    = CRS_W + MID_W + FINE_W;
    localparam int CRS_PERIOD = (1 << CRS_W) - 1;
    localparam int BITCNT_W  = $clog2(CODE_W + 1);

    // feedback from stages 8, 6, 5 and 4 (bit indices 7, 5, 4, 3)
    localparam logic [CRS_W-1:0] CRS_TAPS = 8'hB8;
    localparam logic [CRS_W-1:0] CRS_SEED = 8'h01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_CAPT,
        ST_HOLD
    } tdc_state_e;

    typedef struct packed {
        logic [CRS_W-1:0]  crs;
        logic [MID_W-1:0]  mid;
        logic [FINE_W-1:0] fine;
    } tdc_code_t;

    function automatic logic [CRS_W-1:0] lfsr_next(input logic [CRS_W-1:0] s);
        return {s[CRS_W-2:0], ^(s & CRS_TAPS)};
    endfunction

    function automatic logic [CRS_W-1:0] lfsr_advance(input logic [CRS_W-1:0] s, input int n);
        logic [CRS_W-1:0] t;
        t = s;
        for (int i = 0; i < CRS_PERIOD; i++) begin
            if (i < n) t = lfsr_next(t);
        end
        return t;
    endfunction

    // position of state x in the sequence that starts at the seed
    function automatic logic [CRS_W-1:0] lfsr_decode(input logic [CRS_W-1:0] x);
        logic [CRS_W-1:0] t;
        logic [CRS_W-1:0] idx;
        t   = CRS_SEED;
        idx = '0;
        for (int i = 0; i < CRS_PERIOD; i++) begin
            if (t == x) idx = CRS_W'(i);
            t = lfsr_next(t);
        end
        return idx;
    endfunction

    // last state before the sequence would return to the seed
    localparam logic [CRS_W-1:0] CRS_LAST = lfsr_advance(CRS_SEED, CRS_PERIOD - 1);
endpackage

// File: rtl/tdc_fine_enc.sv
module tdc_fine_enc #(
    parameter int THERM_W = tdc_pkg::THERM_W,
    parameter int BIN_W   = tdc_pkg::FINE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic [THERM_W-1:0] therm_i,
    output logic [BIN_W-1:0]   fine_o
);
    localparam int CNT_W   = $clog2(THERM_W + 1);
    localparam int BIN_MAX = (1 << BIN_W) - 1;

    logic [CNT_W-1:0] ones;
    logic [BIN_W-1:0] bin;

    // a ones count tolerates bubbles in the thermometer word
    always_comb begin
        ones = '0;
        for (int i = 0; i < THERM_W; i++) begin
            ones = ones + CNT_W'(therm_i[i]);
        end
        if (int'(ones) > BIN_MAX) bin = BIN_W'(BIN_MAX);
        else                      bin = BIN_W'(ones);
    end

    always_ff @(posedge clk) begin
        if (rst)         fine_o <= '0;
        else if (cap_en) fine_o <= bin;
    end

    // R5
    fine_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(fine_o));
endmodule

// File: rtl/tdc_mid_coarse.sv
module tdc_mid_coarse
    import tdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic             freeze,
    output logic [MID_W-1:0] mid_o,
    output logic [CRS_W-1:0] lfsr_o,
    output logic             wrap_o
);
    logic mid_top;

    assign mid_top = (mid_o == {MID_W{1'b1}});
    assign wrap_o  = mid_top && (lfsr_o == CRS_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mid_o  <= '0;
            lfsr_o <= CRS_SEED;
        end else if (cnt_en) begin
            if (!freeze) mid_o <= mid_o + 1'b1;
            // divided-clock edge: the coarse stage steps when the divider rolls over
            if (mid_top) lfsr_o <= lfsr_next(lfsr_o);
        end
    end

    // R3
    mid_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && freeze && !clr) |=> $stable(mid_o));

    // R4
    crs_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(cnt_en && mid_top)) |=> $stable(lfsr_o));
endmodule

// File: rtl/tdc_shift_chain.sv
module tdc_shift_chain #(
    parameter int W = tdc_pkg::CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    output logic         ser_o
);
    logic [W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)           chain <= '0;
        else if (load)     chain <= load_val;
        else if (shift_en) chain <= {chain[W-2:0], 1'b0};
    end

    assign ser_o = chain[W-1];

    // R11
    ser_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift_en) |=> $stable(ser_o));
endmodule

// File: rtl/tdc_pixel.sv
module tdc_pixel
    import tdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [THERM_W-1:0] fine_therm_i,
    input  logic               shift_en_i,
    output logic               busy_o,
    output logic               ready_o,
    output logic               ovf_o,
    output logic               ser_o
);
    tdc_state_e          state, state_nx;
    logic [BITCNT_W-1:0] bits_left;
    logic [MID_W-1:0]    mid_q;
    logic [CRS_W-1:0]    lfsr_q;
    logic [FINE_W-1:0]   fine_q;
    logic [CRS_W-1:0]    crs_dec;
    logic                wrap;
    logic                wrap_hit;
    logic                cnt_en;
    logic                clr;
    logic                fine_cap;
    logic                load;
    logic                shift;
    logic                last_shift;
    tdc_code_t           code;
    logic [CODE_W-1:0]   load_val;

    assign wrap_hit   = (state == ST_RUN) && wrap;
    assign cnt_en     = (state == ST_RUN) && !wrap;
    assign clr        = (state == ST_IDLE) && start_i;
    assign fine_cap   = cnt_en && stop_i;
    assign load       = (state == ST_CAPT) || wrap_hit;
    assign shift      = (state == ST_HOLD) && shift_en_i;
    assign last_shift = shift && (bits_left == BITCNT_W'(1));

    tdc_mid_coarse u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .cnt_en (cnt_en),
        .freeze (stop_i),
        .mid_o  (mid_q),
        .lfsr_o (lfsr_q),
        .wrap_o (wrap)
    );

    tdc_fine_enc #(.THERM_W(THERM_W), .BIN_W(FINE_W)) u_fine (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (fine_cap),
        .therm_i (fine_therm_i),
        .fine_o  (fine_q)
    );

    // delayed coarse sample: a divider roll-over at the stop edge is taken back
    always_comb begin
        crs_dec   = lfsr_decode(lfsr_q);
        code.crs  = crs_dec - CRS_W'(mid_q == {MID_W{1'b1}});
        code.mid  = mid_q;
        code.fine = fine_q;
        load_val  = wrap_hit ? {CODE_W{1'b1}} : code;
    end

    tdc_shift_chain #(.W(CODE_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .shift_en (shift),
        .ser_o    (ser_o)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_i) state_nx = ST_RUN;
            ST_RUN: begin
                if (wrap)        state_nx = ST_HOLD;
                else if (stop_i) state_nx = ST_CAPT;
            end
            ST_CAPT: state_nx = ST_HOLD;
            ST_HOLD: if (last_shift) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bits_left <= '0;
            ovf_o     <= 1'b0;
        end else begin
            state <= state_nx;
            if (load)       bits_left <= BITCNT_W'(CODE_W);
            else if (shift) bits_left <= bits_left - 1'b1;
            if (wrap_hit)                             ovf_o <= 1'b1;
            else if (last_shift || state == ST_CAPT)  ovf_o <= 1'b0;
        end
    end

    assign busy_o  = (state == ST_RUN) || (state == ST_CAPT);
    assign ready_o = (state == ST_HOLD);

    // R6
    ready_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && stop_i && !wrap) |-> ##2 ready_o);

    // R7
    ovf_ser_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_o && ovf_o) |-> ser_o);

    // R9
    start_ign_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i) |=> !busy_o);

    // R10
    stop_ign_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !ready_o && stop_i && !start_i) |=> !ready_o);

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        last_shift |=> (!ready_o && !ovf_o));
endmodule

// File: tb/tdc_pixel_tb.sv
`timescale 1ns/1ps
module tdc_pixel_tb;
    localparam int CLK_PERIOD = 4;
    localparam int NVEC = 8;
    // {delay in cycles between start edge and stop edge minus one, thermometer word}
    localparam logic [18:0] VECS [NVEC] = '{
        {11'd0,    8'b0000_0000},
        {11'd3,    8'b0000_0111},
        {11'd4,    8'b0000_1111},
        {11'd7,    8'b1111_1111},
        {11'd42,   8'b0101_0011},
        {11'd255,  8'b0000_0001},
        {11'd515,  8'b0011_1111},
        {11'd1018, 8'b0111_1111}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] fine_therm_i = '0;
    logic       shift_en_i = 1'b0;
    logic       busy_o, ready_o, ovf_o, ser_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tdc_pixel u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .fine_therm_i (fine_therm_i),
        .shift_en_i   (shift_en_i),
        .busy_o       (busy_o),
        .ready_o      (ready_o),
        .ovf_o        (ovf_o),
        .ser_o        (ser_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fine_ref(input logic [7:0] t);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(t[i]);
        return (n > 7) ? 7 : n;
    endfunction

    // starts at a falling edge; returns at the falling edge just after the stop edge
    task automatic convert(input int d, input logic [7:0] therm);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        repeat (d) @(negedge clk);
        stop_i = 1'b1;
        fine_therm_i = therm;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic read_code(output logic [12:0] code);
        shift_en_i = 1'b1;
        for (int i = 12; i >= 0; i--) begin
            code[i] = ser_o;
            @(negedge clk);
        end
        shift_en_i = 1'b0;
        chk(ready_o == 1'b0, "R8 ready clears after 13 shifts", int'(ready_o), 0);
        chk(ovf_o == 1'b0, "R8 ovf clears after drain", int'(ovf_o), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [12:0] code;
        logic        held;
        repeat (3) @(negedge clk);
        chk({busy_o, ready_o, ovf_o, ser_o} == 4'b0, "R1 outputs in reset",
            int'({busy_o, ready_o, ovf_o, ser_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy_o, ready_o, ovf_o, ser_o} == 4'b0, "R1 outputs after reset",
            int'({busy_o, ready_o, ovf_o, ser_o}), 0);

        // R10: stop while idle
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !ready_o, "R10 stop in idle ignored", int'({busy_o, ready_o}), 0);

        for (int v = 0; v < NVEC; v++) begin
            int d;
            logic [7:0] th;
            d  = int'(VECS[v][18:8]);
            th = VECS[v][7:0];
            convert(d, th);
            chk(ready_o == 1'b0 && busy_o == 1'b1, "R6 not ready one edge after stop",
                int'({busy_o, ready_o}), 2);
            @(negedge clk);
            chk(ready_o == 1'b1 && busy_o == 1'b0, "R6 ready two edges after stop",
                int'({busy_o, ready_o}), 1);
            chk(ser_o == 1'(d >> 9), "R8 MSB visible before shifting", int'(ser_o), (d >> 9) & 1);
            read_code(code);
            if ((d % 4) == 3)
                chk(code[12:3] == 10'(d), "R4 boundary coarse/middle", int'(code[12:3]), d);
            else
                chk(code[12:3] == 10'(d), "R3 coarse/middle", int'(code[12:3]), d);
            chk(int'(code[2:0]) == fine_ref(th), "R5 fine", int'(code[2:0]), fine_ref(th));
        end

        // R9 and R11: start and idle shift while ready
        convert(10, 8'b0000_0011);
        @(negedge clk);
        held = ser_o;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready_o && !busy_o, "R9 start while ready ignored", int'({busy_o, ready_o}), 1);
        chk(ser_o == held, "R11 ser holds without shift", int'(ser_o), int'(held));
        read_code(code);
        chk(code == {10'd10, 3'd2}, "R9 held code unchanged", int'(code), int'({10'd10, 3'd2}));

        // R7: no stop
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (1030) @(negedge clk);
        chk(ready_o && ovf_o, "R7 overflow flagged", int'({ready_o, ovf_o}), 3);
        read_code(code);
        chk(code == 13'h1FFF, "R7 overflow code", int'(code), 13'h1FFF);

        // R7: stop on the overflow edge
        convert(1019, 8'b0000_0001);
        chk(ready_o && ovf_o, "R7 overflow wins over stop", int'({ready_o, ovf_o}), 3);
        read_code(code);
        chk(code == 13'h1FFF, "R7 overflow code with stop", int'(code), 13'h1FFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule